// File: doc/BRIEF.md
# External Interrupt Request Conditioner

This block sits between two active-low interrupt pins and the CPU's exception logic. One pin carries a maskable request. Software chooses whether that request is taken on a falling edge or while the line is held low. The other pin carries a nonmaskable request that is always level-sensitive, so several open-drain sources can share one wired-OR line. Both pins pass through a synchroniser before any decision is made.

The block holds the two mask bits. I gates the maskable request and X gates the nonmaskable one, and reset sets both. Software reaches the block through a three-bit write port, which loads the trigger mode and can clear either mask. Software can never set X. The CPU reports each interrupt it takes on the acknowledge input. An acknowledge sets I, and a nonmaskable acknowledge also sets X, which keeps the service routine from being re-entered. When both requests are pending and unmasked, only the nonmaskable one is presented.

Top module: `irq_cond_top`

## Requirements
- R1: While reset is asserted and on the first cycle after it, `maskI` and `maskX` are 1, `edgeMode` is 0 (level triggering), and `irqReq` and `nmiReq` are 0.
- R2: Each pin passes through two flip-flops. In level mode with I clear, a low on `irqPinN` first shows on `irqReq` after the second rising clock edge, and not after the first.
- R3: A cycle with `cfgWrEn` high loads `cfgWrData[0]` into `edgeMode` (1 = falling edge, 0 = low level). It clears I when `cfgWrData[1]` is 1 and clears X when `cfgWrData[2]` is 1. A 0 in bit 1 or bit 2 leaves that mask unchanged.
- R4: In level mode, `irqReq` is high whenever the synchronised maskable line is low, I is 0 and no nonmaskable request is presented. If the line is still low when I is cleared, `irqReq` rises on the next cycle.
- R5: In edge mode, a falling edge on `irqPinN` latches a pending request, visible on `irqReq` after the third rising edge when I is clear. The request stays pending after the pin returns high. A line held low without a new edge raises nothing.
- R6: `nmiReq` is high exactly when the synchronised nonmaskable line is low and X is 0. With X set, a low line raises nothing.
- R7: A write can never set X. Only reset or a nonmaskable acknowledge sets it.
- R8: `irqReq` is 0 in every cycle in which `nmiReq` is 1.
- R9: `ack` sets I on the next edge, and `ack` with `ackNmi` high also sets X. If an acknowledge and a write clearing the same mask fall in the same cycle, the mask ends up set.
- R10: A maskable acknowledge (`ack` with `ackNmi` low) clears the edge-mode pending request, unless a new falling edge arrives in the same cycle. While level mode is selected, no edge request stays pending, so returning to edge mode starts with nothing pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, asserted asynchronously |
| irqPinN | input | 1 | Maskable interrupt pin, active low, asynchronous |
| nmiPinN | input | 1 | Nonmaskable interrupt pin, active low, asynchronous |
| cfgWrEn | input | 1 | Write strobe for the control bits |
| cfgWrData | input | 3 | Bit 0 trigger mode, bit 1 clear I, bit 2 clear X |
| ack | input | 1 | CPU has taken an interrupt |
| ackNmi | input | 1 | With ack: the interrupt taken was the nonmaskable one |
| irqReq | output | 1 | Maskable request presented to the CPU |
| nmiReq | output | 1 | Nonmaskable request presented to the CPU |
| maskI | output | 1 | Current maskable-interrupt mask |
| maskX | output | 1 | Current nonmaskable-interrupt mask |
| edgeMode | output | 1 | Current trigger mode of the maskable input |

## Verification
The assertions watch the relations that must hold on every cycle. Nonmaskable priority over the maskable request, the gating by I and X, the sources that may set X, acknowledge setting I, and the ways the edge latch may drop are all checked continuously. The exact synchroniser latency, the three-cycle delay of an edge request, and recognition of a still-low line right after I is cleared can only be shown by timed bench scenarios. The same holds for a held-low line producing nothing in edge mode and for the same-cycle acknowledge-versus-write ordering. A cycle-by-cycle reference model under random pin, write and acknowledge traffic covers these.

// File: rtl/irq_cond_pkg.sv
package irq_cond_pkg;

  localparam int CFG_W       = 3;
  localparam int CFG_MODE    = 0;
  localparam int CFG_CLR_I   = 1;
  localparam int CFG_CLR_X   = 2;

  // Strobes from control to datapath, valid for one cycle.
  typedef struct packed {
    logic setI;
    logic setX;
    logic clrI;
    logic clrX;
    logic loadMode;
    logic modeVal;
    logic ackMask;
  } ctl_strobe_t;

endpackage

// File: rtl/irq_cond_dp.sv
module irq_cond_dp
  import irq_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        irqPinN,
  input  logic        nmiPinN,
  input  ctl_strobe_t strb,
  output logic        irqLineLow,
  output logic        nmiLineLow,
  output logic        edgePend,
  output logic        maskI,
  output logic        maskX,
  output logic        edgeMode
);

  localparam int NUM_PINS = 2;
  localparam logic [SYNC_STAGES-1:0] IDLE_HIGH = '1;

  logic [NUM_PINS-1:0] pinsN;
  logic [NUM_PINS-1:0] syncN;
  logic                prevIrqN;
  logic                irqFall;

  assign pinsN = {nmiPinN, irqPinN};

  // One synchroniser chain per pin; idle level is high.
  for (genvar p = 0; p < NUM_PINS; p++) begin : g_sync
    logic [SYNC_STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= IDLE_HIGH;
      else        chain <= {chain[SYNC_STAGES-2:0], pinsN[p]};
    end
    assign syncN[p] = chain[SYNC_STAGES-1];
  end

  assign irqLineLow = ~syncN[0];
  assign nmiLineLow = ~syncN[1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prevIrqN <= 1'b1;
    else        prevIrqN <= syncN[0];
  end

  assign irqFall = prevIrqN & ~syncN[0];

  // Edge latch: held empty in level mode; a new edge beats an acknowledge.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             edgePend <= 1'b0;
    else if (!edgeMode)     edgePend <= 1'b0;
    else if (irqFall)       edgePend <= 1'b1;
    else if (strb.ackMask)  edgePend <= 1'b0;
  end

  // Mask bits: hardware set wins over a software clear.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      maskI <= 1'b1;
      maskX <= 1'b1;
    end else begin
      if (strb.setI)      maskI <= 1'b1;
      else if (strb.clrI) maskI <= 1'b0;
      if (strb.setX)      maskX <= 1'b1;
      else if (strb.clrX) maskX <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             edgeMode <= 1'b0;
    else if (strb.loadMode) edgeMode <= strb.modeVal;
  end

  // R7
  x_set_source_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(maskX) |-> $past(strb.setX));

  // R9
  ack_sets_i_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strb.setI |=> maskI);

  // R10
  edge_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(edgePend) |-> $past(strb.ackMask || !edgeMode));

endmodule

// File: rtl/irq_cond_ctl.sv
module irq_cond_ctl
  import irq_cond_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfgWrEn,
  input  logic [CFG_W-1:0]  cfgWrData,
  input  logic              ack,
  input  logic              ackNmi,
  input  logic              irqLineLow,
  input  logic              nmiLineLow,
  input  logic              edgePend,
  input  logic              maskI,
  input  logic              maskX,
  input  logic              edgeMode,
  output ctl_strobe_t       strb,
  output logic              irqReq,
  output logic              nmiReq
);

  logic maskSource;

  always_comb begin
    strb          = '0;
    strb.setI     = ack;
    strb.setX     = ack & ackNmi;
    strb.ackMask  = ack & ~ackNmi;
    strb.loadMode = cfgWrEn;
    strb.modeVal  = cfgWrData[CFG_MODE];
    strb.clrI     = cfgWrEn & cfgWrData[CFG_CLR_I];
    strb.clrX     = cfgWrEn & cfgWrData[CFG_CLR_X];
  end

  assign maskSource = edgeMode ? edgePend : irqLineLow;
  assign nmiReq     = nmiLineLow & ~maskX;
  assign irqReq     = maskSource & ~maskI & ~nmiReq;

  // R8
  nmi_priority_chk: assert property (@(posedge clk) disable iff (!rst_n)
    nmiReq |-> !irqReq);

  // R6
  x_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskX |-> !nmiReq);

  // R4
  i_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    maskI |-> !irqReq);

endmodule

// File: rtl/irq_cond_top.sv
module irq_cond_top
  import irq_cond_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irqPinN,
  input  logic             nmiPinN,
  input  logic             cfgWrEn,
  input  logic [CFG_W-1:0] cfgWrData,
  input  logic             ack,
  input  logic             ackNmi,
  output logic             irqReq,
  output logic             nmiReq,
  output logic             maskI,
  output logic             maskX,
  output logic             edgeMode
);

  ctl_strobe_t strb;
  logic        irqLineLow;
  logic        nmiLineLow;
  logic        edgePend;

  irq_cond_dp #(.SYNC_STAGES(SYNC_STAGES)) i_dp (
    .clk        (clk),
    .rst_n      (rst_n),
    .irqPinN    (irqPinN),
    .nmiPinN    (nmiPinN),
    .strb       (strb),
    .irqLineLow (irqLineLow),
    .nmiLineLow (nmiLineLow),
    .edgePend   (edgePend),
    .maskI      (maskI),
    .maskX      (maskX),
    .edgeMode   (edgeMode)
  );

  irq_cond_ctl i_ctl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cfgWrEn    (cfgWrEn),
    .cfgWrData  (cfgWrData),
    .ack        (ack),
    .ackNmi     (ackNmi),
    .irqLineLow (irqLineLow),
    .nmiLineLow (nmiLineLow),
    .edgePend   (edgePend),
    .maskI      (maskI),
    .maskX      (maskX),
    .edgeMode   (edgeMode),
    .strb       (strb),
    .irqReq     (irqReq),
    .nmiReq     (nmiReq)
  );

endmodule

// File: tb/test_irq_cond_top.sv
module test_irq_cond_top;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       irqPinN = 1'b1;
  logic       nmiPinN = 1'b1;
  logic       cfgWrEn = 1'b0;
  logic [2:0] cfgWrData = 3'b000;
  logic       ack = 1'b0;
  logic       ackNmi = 1'b0;
  logic       irqReq, nmiReq, maskI, maskX, edgeMode;

  int checks = 0;
  int errors = 0;
  bit modelOn = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  irq_cond_top i_irq_cond_top (
    .clk(clk), .rst_n(rst_n), .irqPinN(irqPinN), .nmiPinN(nmiPinN),
    .cfgWrEn(cfgWrEn), .cfgWrData(cfgWrData), .ack(ack), .ackNmi(ackNmi),
    .irqReq(irqReq), .nmiReq(nmiReq), .maskI(maskI), .maskX(maskX),
    .edgeMode(edgeMode)
  );

  // Reference state built from the requirements.
  logic mI1, mI2, mPrev, mN1, mN2, mPend, mMaskI, mMaskX, mMode;

  function automatic logic expNmi();
    return ~mN2 & ~mMaskX;
  endfunction

  function automatic logic expIrq();
    logic src;
    src = mMode ? mPend : ~mI2;
    return src & ~mMaskI & ~expNmi();
  endfunction

  function automatic logic [4:0] expVec();
    return {expIrq(), expNmi(), mMaskI, mMaskX, mMode};
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      mI1 <= 1'b1; mI2 <= 1'b1; mPrev <= 1'b1; mN1 <= 1'b1; mN2 <= 1'b1;
      mPend <= 1'b0; mMaskI <= 1'b1; mMaskX <= 1'b1; mMode <= 1'b0;
    end else begin
      mI1 <= irqPinN; mI2 <= mI1; mPrev <= mI2;
      mN1 <= nmiPinN; mN2 <= mN1;
      if (!mMode)                 mPend <= 1'b0;
      else if (mPrev && !mI2)     mPend <= 1'b1;
      else if (ack && !ackNmi)    mPend <= 1'b0;
      if (ack)                            mMaskI <= 1'b1;
      else if (cfgWrEn && cfgWrData[1])   mMaskI <= 1'b0;
      if (ack && ackNmi)                  mMaskX <= 1'b1;
      else if (cfgWrEn && cfgWrData[2])   mMaskX <= 1'b0;
      if (cfgWrEn) mMode <= cfgWrData[0];
    end
  end

  task automatic check(string tag, logic [4:0] act, logic [4:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %b expected %b (irq nmi I X mode)", tag, act, exp);
    end
  endtask

  function automatic logic [4:0] outVec();
    return {irqReq, nmiReq, maskI, maskX, edgeMode};
  endfunction

  // Whole-state comparison on every cycle, away from the rising edge.
  always @(negedge clk) begin
    if (modelOn && rst_n) check("R2 R4 R5 R6 R8 model", outVec(), expVec());
  end

  task automatic step(int n = 1);
    for (int k = 0; k < n; k++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic wr(logic [2:0] d);
    cfgWrEn = 1'b1; cfgWrData = d;
    step();
    cfgWrEn = 1'b0; cfgWrData = 3'b000;
  endtask

  task automatic doAck(logic isNmi);
    ack = 1'b1; ackNmi = isNmi;
    step();
    ack = 1'b0; ackNmi = 1'b0;
  endtask

  task automatic finish();
    if (!finished) begin
      finished = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  int wdog = 0;
  always @(posedge clk) begin
    wdog++;
    if (wdog > 150000) begin
      checks++; errors++;
      $display("FAIL watchdog expired");
      finish();
    end
  end

  initial begin
    void'($urandom(32'd4711));
    @(negedge clk);
    check("R1 in reset", outVec(), 5'b00110);
    step(2);
    rst_n = 1'b1;
    step();
    check("R1 after reset", outVec(), 5'b00110);
    modelOn = 1'b1;

    // R7: write without clear bits leaves X set
    wr(3'b000);
    check("R7 write cannot set X", {3'b0, maskX, 1'b0}, 5'b00010);

    // R6: X blocks a low NMI line
    nmiPinN = 1'b0;
    step(3);
    check("R6 masked by X", {3'b0, nmiReq, 1'b0}, 5'b0);
    wr(3'b100);
    check("R6 request after X clear", {3'b0, nmiReq, maskX}, 5'b00010);

    // R9: NMI acknowledge sets I and X
    doAck(1'b1);
    check("R9 nmi ack", {1'b0, nmiReq, maskI, maskX, 1'b0}, 5'b00110);
    nmiPinN = 1'b1;
    step(3);
    wr(3'b100);
    check("R7 clear X again", {3'b0, maskX, 1'b0}, 5'b0);

    // R2: two-stage latency, level mode
    wr(3'b010);
    irqPinN = 1'b0;
    step();
    check("R2 not after first edge", {4'b0, irqReq}, 5'b0);
    step();
    check("R2 after second edge", {4'b0, irqReq}, 5'b1);

    // R8: NMI preempts maskable
    nmiPinN = 1'b0;
    step(2);
    check("R8 nmi priority", {3'b0, nmiReq, irqReq}, 5'b00010);
    nmiPinN = 1'b1;
    step(2);
    check("R8 maskable returns", {3'b0, nmiReq, irqReq}, 5'b00001);

    // R4: still-low line recognised right after I is cleared
    doAck(1'b0);
    check("R4 ack masks", {3'b0, maskI, irqReq}, 5'b00010);
    wr(3'b010);
    check("R4 immediate re-request", {4'b0, irqReq}, 5'b1);

    // R9: acknowledge beats clear in the same cycle
    ack = 1'b1; cfgWrEn = 1'b1; cfgWrData = 3'b010;
    step();
    ack = 1'b0; cfgWrEn = 1'b0; cfgWrData = 3'b000;
    check("R9 ack beats clear", {4'b0, maskI}, 5'b1);

    // R3 / R5: edge mode, line already low gives nothing
    wr(3'b011);
    check("R3 mode loaded", {maskI, 3'b0, edgeMode}, 5'b00001);
    step(3);
    check("R5 held low no edge", {4'b0, irqReq}, 5'b0);
    irqPinN = 1'b1;
    step(3);
    irqPinN = 1'b0;
    step(2);
    check("R5 not before third edge", {4'b0, irqReq}, 5'b0);
    step();
    check("R5 edge latched", {4'b0, irqReq}, 5'b1);
    irqPinN = 1'b1;
    step(4);
    check("R5 stays pending", {4'b0, irqReq}, 5'b1);
    doAck(1'b0);
    wr(3'b011);
    check("R10 ack cleared pending", {4'b0, irqReq}, 5'b0);

    // R10: level mode empties the edge latch
    irqPinN = 1'b0;
    step(3);
    irqPinN = 1'b1;
    wr(3'b010);
    step(3);
    wr(3'b011);
    step(2);
    check("R10 level mode drops pending", {4'b0, irqReq}, 5'b0);

    // Random traffic against the reference model
    for (int c = 0; c < 4000; c++) begin
      if ($urandom_range(0, 5) == 0) irqPinN = ~irqPinN;
      if ($urandom_range(0, 9) == 0) nmiPinN = ~nmiPinN;
      cfgWrEn   = ($urandom_range(0, 7) == 0);
      cfgWrData = 3'($urandom_range(0, 7));
      ack       = ($urandom_range(0, 7) == 0);
      ackNmi    = ($urandom_range(0, 1) == 1);
      step();
    end
    cfgWrEn = 1'b0; ack = 1'b0;
    step(2);
    finish();
  end

endmodule